// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit signed accumulator. The accumulator is held as two 32-bit words. The upper word sits above the lower word, and the pair is read as one two's-complement value. Two operation widths are offered. The long operation multiplies full 32-bit operands. The word operation multiplies only the low 16 bits of each operand, with each half sign-extended. An optional saturation mode clips the result after each operation, and the clipping rule depends on the operation width.

A host starts an operation with a one-cycle `start` strobe. It then waits for the one-cycle `done` pulse, which marks the cycle in which the new accumulator value is visible. Between operations the host can clear both words with `clr`, or load either word directly through the write port. The controller has three states:

- IDLE waits for `start`. On `start` it latches the operands, the width and the saturation mode, then moves to MUL.
- MUL registers the sign-extended product, then always moves to ACC.
- ACC adds the product, applies saturation, writes both words and raises `done`, then always returns to IDLE.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero, and `busy` and `done` are low.
- R2: The accumulator is the signed value {`acc_hi`, `acc_lo`}. A long operation (`op_long`=1) with `sat_en`=0 adds the signed 32×32 product of `opa` and `opb` to the accumulator, wrapped modulo 2^64.
- R3: A word operation (`op_long`=0) uses only bits 15:0 of each operand, each sign-extended, and ignores bits 31:16. With `sat_en`=0 it adds the product to the accumulator, wrapped modulo 2^64.
- R4: A long operation with `sat_en`=1 first forms the wrapped 64-bit sum. It writes the low 32 bits of the sum to `acc_lo`. If bit 63 of the sum is 1, `acc_hi` is the sum's upper word with bits 31:16 forced to 1. Otherwise `acc_hi` is the sum's upper word with bits 31:15 cleared.
- R5: A word operation with `sat_en`=1 whose sum is below −2^31 writes `acc_hi`=1 and `acc_lo`=0x80000000. A sum of exactly −2^31 is written unchanged.
- R6: A word operation with `sat_en`=1 whose sum is above 2^31−1 writes `acc_hi`=1 and `acc_lo`=0x7FFFFFFF. A sum within [−2^31, 2^31−1], including 2^31−1 itself, is written unchanged.
- R7: `start` sampled in IDLE at clock edge k updates the accumulator at edge k+2. `done` is high for exactly the one cycle that follows edge k+2. `busy` is high between edges k and k+2.
- R8: `start` is ignored while `busy` is high. An operation runs MUL then ACC and returns to IDLE, without repeating or stalling.
- R9: `clr` zeroes both accumulator words at the next edge in any state. It takes priority over host writes and over a completing operation.
- R10: In IDLE, `wr_hi` loads `wr_data` into `acc_hi` and `wr_lo` loads `wr_data` into `acc_lo`. Both writes are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| op_long | input | 1 | 1 = long 32×32 operation, 0 = word 16×16 operation |
| sat_en | input | 1 | 1 = saturating mode |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr | input | 1 | Zero both accumulator words |
| wr_hi | input | 1 | Load `wr_data` into the upper word (idle only) |
| wr_lo | input | 1 | Load `wr_data` into the lower word (idle only) |
| wr_data | input | 32 | Host write data |
| acc_hi | output | 32 | Accumulator upper word |
| acc_lo | output | 32 | Accumulator lower word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
The assertions check these on every cycle:

- the fixed MUL→ACC→IDLE walk and the single-cycle `done` pulse;
- the accumulator holding still through MUL;
- `clr` zeroing the words;
- the shape of every saturated result. A long saturated upper word has its top bits all ones or all zeros. A word saturated upper word is either 1 or the sign extension of the lower word.

Only the bench scenarios can show that the values are correct. These scenarios cover:

- the exact products and sums;
- carry between the words;
- the exact saturation thresholds at −2^31 and 2^31−1;
- operand upper halves being ignored in word mode;
- the two-edge latency;
- `start` and host writes being ignored while busy.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic mul_en,
    output logic acc_en,
    output logic busy,
    output logic done
);
    mac_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and decoded outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        mul_en   = 1'b0;
        acc_en   = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    load     = 1'b1;
                    state_nx = ST_MUL;
                end
            end
            ST_MUL: begin
                mul_en   = 1'b1;
                state_nx = ST_ACC;
            end
            ST_ACC: begin
                acc_en   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // registered completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_ACC);
    end

    // R8
    mul_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUL) |=> (state == ST_ACC));
    // R8
    acc_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC) |=> (state == ST_IDLE));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            mul_en,
    input  logic            op_long,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] xa_q, xb_q;
    logic [PW-1:0] xa_d, xb_d;

    // operand extension picked by operation width
    always_comb begin
        if (op_long) begin
            xa_d = {{(PW-DW){opa[DW-1]}}, opa};
            xb_d = {{(PW-DW){opb[DW-1]}}, opb};
        end else begin
            xa_d = {{(PW-HW){opa[HW-1]}}, opa[HW-1:0]};
            xb_d = {{(PW-HW){opb[HW-1]}}, opb[HW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa_q <= '0;
            xb_q <= '0;
            prod <= '0;
        end else begin
            if (load) begin
                xa_q <= xa_d;
                xb_q <= xb_d;
            end
            if (mul_en) prod <= xa_q * xb_q;
        end
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0]   acc_hi,
    input  logic [DW-1:0]   acc_lo,
    input  logic [2*DW-1:0] prod,
    input  logic            op_long,
    input  logic            sat_en,
    output logic [DW-1:0]   res_hi,
    output logic [DW-1:0]   res_lo
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] HI_SET  = {{HW{1'b1}}, {(DW-HW){1'b0}}};
    localparam logic [DW-1:0] HI_KEEP = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [PW-1:0] POS_LIM = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [PW-1:0] NEG_LIM = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LO_MAX  = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] LO_MIN  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] HI_FLAG = {{(DW-1){1'b0}}, 1'b1};

    logic [PW-1:0] sum;
    logic          too_big, too_small;

    always_comb begin
        sum       = {acc_hi, acc_lo} + prod;
        too_big   = $signed(sum) > $signed(POS_LIM);
        too_small = $signed(sum) < $signed(NEG_LIM);
        res_hi    = sum[PW-1:DW];
        res_lo    = sum[DW-1:0];
        if (sat_en) begin
            if (op_long) begin
                if (sum[PW-1]) res_hi = sum[PW-1:DW] | HI_SET;
                else           res_hi = sum[PW-1:DW] & HI_KEEP;
            end else if (too_big) begin
                res_hi = HI_FLAG;
                res_lo = LO_MAX;
            end else if (too_small) begin
                res_hi = HI_FLAG;
                res_lo = LO_MIN;
            end
        end
    end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import mac_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_long,
    input  logic          sat_en,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          clr,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic          busy,
    output logic          done
);
    localparam int PW = 2 * DW;

    logic          load, mul_en, acc_en;
    logic          op_q, sat_q;
    logic [PW-1:0] prod;
    logic [DW-1:0] res_hi, res_lo;

    mac_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .mul_en (mul_en),
        .acc_en (acc_en),
        .busy   (busy),
        .done   (done)
    );

    mac_mult #(.DW(DW), .HW(HW)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .mul_en  (mul_en),
        .op_long (op_long),
        .opa     (opa),
        .opb     (opb),
        .prod    (prod)
    );

    mac_sat #(.DW(DW), .HW(HW)) u_sat (
        .acc_hi  (acc_hi),
        .acc_lo  (acc_lo),
        .prod    (prod),
        .op_long (op_q),
        .sat_en  (sat_q),
        .res_hi  (res_hi),
        .res_lo  (res_lo)
    );

    // mode captured with the operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= 1'b0;
            sat_q <= 1'b0;
        end else if (load) begin
            op_q  <= op_long;
            sat_q <= sat_en;
        end
    end

    // accumulator words: clear, then result, then idle host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (clr) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (acc_en) begin
            acc_hi <= res_hi;
            acc_lo <= res_lo;
        end else if (!busy) begin
            if (wr_hi) acc_hi <= wr_data;
            if (wr_lo) acc_lo <= wr_data;
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0));
    // R10
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en && !clr) |=> ($stable(acc_hi) && $stable(acc_lo)));
    // R4
    long_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q && sat_q) |->
            ((&acc_hi[DW-1:DW-HW]) || (acc_hi[DW-1:HW-1] == '0)));
    // R5, R6
    word_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q && sat_q) |->
            ((acc_hi == {{(DW-1){1'b0}}, 1'b1}) || (acc_hi == {DW{acc_lo[DW-1]}})));
endmodule

// File: tb/sim_sat_mac.sv
module sim_sat_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_long = 1'b0, sat_en = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        clr = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        busy, done;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sat_mac u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_long(op_long), .sat_en(sat_en),
        .opa(opa), .opb(opb), .clr(clr), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic        lng;
        logic        sat;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] ih;
        logic [31:0] il;
        logic [31:0] eh;
        logic [31:0] el;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h00000003, 32'h00000005, 32'h0, 32'h0,        32'h00000000, 32'h0000000F},
        '{1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF},
        '{1'b1, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 32'h0,        32'h3FFFFFFF, 32'h00000001},
        '{1'b1, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 32'h0,        32'h00007FFF, 32'h00000001},
        '{1'b1, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'h0, 32'h0,        32'hFFFF0000, 32'h80000000},
        '{1'b1, 1'b1, 32'h00000001, 32'h00000001, 32'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
        '{1'b0, 1'b0, 32'h12340003, 32'hABCDFFFE, 32'h0, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFA},
        '{1'b0, 1'b1, 32'h00000004, 32'h00000004, 32'h0, 32'h7FFFFFF0, 32'h00000001, 32'h7FFFFFFF},
        '{1'b0, 1'b1, 32'h0000FFFF, 32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'h00000001, 32'h80000000},
        '{1'b0, 1'b1, 32'h00008000, 32'h00008000, 32'h0, 32'h0,        32'h00000000, 32'h40000000},
        '{1'b0, 1'b1, 32'h00000001, 32'h00000001, 32'h0, 32'h7FFFFFFE, 32'h00000000, 32'h7FFFFFFF},
        '{1'b0, 1'b1, 32'h00000000, 32'h00000000, 32'h10, 32'h0,       32'h00000001, 32'h7FFFFFFF},
        '{1'b0, 1'b0, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h00000000},
        '{1'b0, 1'b1, 32'h0000FFFF, 32'h00000001, 32'hFFFFFFFF, 32'h80000001, 32'hFFFFFFFF, 32'h80000000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_load(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk); wr_hi = 1'b1; wr_data = hi;
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo;
        @(negedge clk); wr_lo = 1'b0;
    endtask

    // returns the number of falling edges from the start strobe to done
    task automatic run_op(input logic lng, input logic sat, input logic [31:0] a,
                          input logic [31:0] b, output int lat);
        @(negedge clk);
        start = 1'b1; op_long = lng; sat_en = sat; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = '0; opb = '0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int ndone;
        string tag;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 acc", {acc_hi, acc_lo}, 64'h0);
        chk("R1 busy", {63'h0, busy}, 64'h0);
        chk("R1 done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            host_load(VEC[i].ih, VEC[i].il);
            run_op(VEC[i].lng, VEC[i].sat, VEC[i].a, VEC[i].b, lat);
            if (VEC[i].lng)      tag = VEC[i].sat ? "R4" : "R2";
            else if (!VEC[i].sat) tag = "R3";
            else tag = (VEC[i].el == 32'h80000000) ? "R5" : "R6";
            chk(tag, {acc_hi, acc_lo}, {VEC[i].eh, VEC[i].el});
        end

        // R7 latency and single-cycle done
        host_load(32'h0, 32'h0);
        run_op(1'b1, 1'b0, 32'd3, 32'd5, lat);
        chk("R7 latency", 64'(lat), 64'd3);
        chk("R7 busy low at done", {63'h0, busy}, 64'h0);
        @(negedge clk);
        chk("R7 done drops", {63'h0, done}, 64'h0);

        // R2 chained accumulation: 15 + (-2*4) = 7
        run_op(1'b1, 1'b0, 32'hFFFFFFFE, 32'd4, lat);
        chk("R2 chain", {acc_hi, acc_lo}, 64'd7);

        // R8 start held high across the whole operation gives one result
        host_load(32'h0, 32'h0);
        @(negedge clk);
        start = 1'b1; op_long = 1'b1; sat_en = 1'b0; opa = 32'd6; opb = 32'd7;
        ndone = 0;
        repeat (3) begin
            @(negedge clk);
            if (done) ndone++;
        end
        start = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk("R8 single done", 64'(ndone), 64'd1);
        chk("R8 single result", {acc_hi, acc_lo}, 64'd42);

        // R10 host writes ignored while busy
        host_load(32'h0, 32'h0);
        @(negedge clk);
        start = 1'b1; op_long = 1'b1; sat_en = 1'b0; opa = 32'd2; opb = 32'd3;
        @(negedge clk);
        start = 1'b0; wr_lo = 1'b1; wr_data = 32'hDEADBEEF;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b1; wr_data = 32'hCAFEF00D;
        @(negedge clk);
        wr_hi = 1'b0;
        chk("R10 writes ignored while busy", {acc_hi, acc_lo}, 64'd6);
        host_load(32'h01234567, 32'h89ABCDEF);
        chk("R10 idle write", {acc_hi, acc_lo}, 64'h01234567_89ABCDEF);

        // R9 clear beats a host write
        @(negedge clk);
        clr = 1'b1; wr_hi = 1'b1; wr_data = 32'h55555555;
        @(negedge clk);
        clr = 1'b0; wr_hi = 1'b0;
        chk("R9 clear", {acc_hi, acc_lo}, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule